// File: doc/BRIEF.md
# Master-Clock Ratio Detector and Frame Resync Controller

This block runs on the master clock of an audio converter and watches the frame clock, which has one period per stereo sample. It counts how many master clocks lie between two rising frame edges and accepts the count only if it is 256, 384, 512 or 768. A ratio is locked once two frames in a row give the same accepted count. A single disturbed frame does not change the locked ratio.

While the ratio is locked, an internal divider runs with the locked period. Each rising frame edge is compared against the divider position. When the edge has drifted further than six bit-clock periods (a frame holds 64 bit clocks), the divider is realigned to that edge. The datapath is then held at mid-scale until the next frame edge arrives on time.

The block also stretches the external reset, so that the internal reset is released a fixed 1024 master clocks later. The same mid-scale force output mutes the datapath during that time.

Top module: `clkratio_ctrl`

## Requirements
- R1: `int_rst_n` is low while `rst_n` is low and through the first 1023 rising `clk` edges after `rst_n` goes high. It is high from the 1024th such edge until `rst_n` falls again, and that fall takes effect at once.
- R2: `force_mid` is high exactly when the internal reset is active or `resync_busy` is high.
- R3: `frame_clk` is sampled on `clk`. A measured period is the number of `clk` edges from one sampled rising frame edge to the next. The first rising edge after internal reset or after a timeout only starts a measurement.
- R4: `ratio_code` encodes 0 = 256, 1 = 384, 2 = 512 and 3 = 768. On the edge that closes the second consecutive period of the same accepted length, `ratio_locked` goes high and the code is loaded.
- R5: A single period that differs from the locked length leaves `ratio_locked` and `ratio_code` unchanged. Two consecutive equal accepted periods of a new length replace the code, and `ratio_locked` stays high through the change.
- R6: `period_bad` shows whether the last measured period was outside the accepted set. Two consecutive equal periods outside that set clear `ratio_locked`.
- R7: If 2047 (2^CNT_W − 1) clocks pass after the last frame edge with no new rising edge, `ratio_locked` clears and `period_bad` sets.
- R8: At each rising frame edge while locked, p is the count of clocks since the last alignment edge, modulo the locked length N. The phase error is min(p, N − p). If it exceeds 6·N/64 clocks (24, 36, 48 or 72), `resync_busy` sets and that edge becomes the new alignment edge. An error equal to the limit has no effect.
- R9: `resync_busy` clears at the next frame edge whose phase error is within the limit. It also clears on a change of locked ratio and when the lock is dropped.
- R10: `frame_tick` is high while locked in exactly those cycles whose closing edge is the expected frame edge, that is, where p = 0. It recurs every N clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset request |
| frame_clk | input | 1 | Frame (sample-rate) clock, synchronous to `clk` |
| int_rst_n | output | 1 | Stretched internal reset, active low |
| force_mid | output | 1 | Forces the datapath to mid-scale |
| ratio_locked | output | 1 | A master-clock ratio is locked |
| ratio_code | output | 2 | Locked ratio: 0=256, 1=384, 2=512, 3=768 |
| period_bad | output | 1 | Last period was not an accepted length, or a timeout occurred |
| resync_busy | output | 1 | A phase resynchronization is in progress |
| frame_tick | output | 1 | Expected frame-edge position of the internal divider |

## Verification
Some properties are checked on every cycle by assertions:
- once released, the internal reset stays released, and the release follows the full count;
- resync is only ever high while locked;
- resync starts only on a measured frame edge, and ends only on a frame edge or a timeout;
- a lock never appears together with a bad period;
- the divider stays below the locked length.

Other properties can only be shown by the bench scenarios:
- the exact 1024-edge release;
- the tolerance boundary, where an error at the limit is ignored and one clock more triggers resync;
- the two-frame confirmation, including a ratio change made while already locked;
- the timeout length;
- the realigned tick position.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;

  localparam int LEN_W     = 16;
  localparam int MAX_RATIO = 768;
  localparam int DIV_W     = $clog2(MAX_RATIO);

  typedef enum logic [1:0] {
    RATIO_256 = 2'd0,
    RATIO_384 = 2'd1,
    RATIO_512 = 2'd2,
    RATIO_768 = 2'd3
  } ratio_e;

  typedef struct packed {
    logic   ok;
    ratio_e code;
  } class_t;

  // Map a measured period length onto one of the accepted ratios.
  function automatic class_t classify(input logic [LEN_W-1:0] len);
    class_t r;
    r.ok   = 1'b1;
    r.code = RATIO_256;
    case (len)
      LEN_W'(256): r.code = RATIO_256;
      LEN_W'(384): r.code = RATIO_384;
      LEN_W'(512): r.code = RATIO_512;
      LEN_W'(768): r.code = RATIO_768;
      default:     r.ok   = 1'b0;
    endcase
    return r;
  endfunction

  // Frame length in master clocks for a ratio code.
  function automatic logic [LEN_W-1:0] frame_len(input ratio_e c);
    case (c)
      RATIO_256: return LEN_W'(256);
      RATIO_384: return LEN_W'(384);
      RATIO_512: return LEN_W'(512);
      default:   return LEN_W'(768);
    endcase
  endfunction

  // Allowed phase error in master clocks: tol_bits bit clocks of the frame.
  function automatic logic [LEN_W-1:0] tol_clocks(input ratio_e c, input int bpf,
                                                  input int tol_bits);
    case (c)
      RATIO_256: return LEN_W'(256 * tol_bits / bpf);
      RATIO_384: return LEN_W'(384 * tol_bits / bpf);
      RATIO_512: return LEN_W'(512 * tol_bits / bpf);
      default:   return LEN_W'(768 * tol_bits / bpf);
    endcase
  endfunction

  // Circular distance of a divider position from zero.
  function automatic logic [LEN_W-1:0] phase_err(input logic [LEN_W-1:0] pos,
                                                 input logic [LEN_W-1:0] n);
    return (pos <= (n >> 1)) ? pos : (n - pos);
  endfunction

endpackage

// File: rtl/clkratio_rst_stretch.sv
module clkratio_rst_stretch #(
  parameter int HOLD_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic int_rst_n
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] hold_cnt;
  logic          rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      rel_q    <= 1'b0;
    end else if (!rel_q) begin
      hold_cnt <= hold_cnt + HW'(1);
      if (hold_cnt == HW'(HOLD_CYCLES - 1)) rel_q <= 1'b1;
    end
  end

  assign int_rst_n = rel_q;

  assert_release_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |=> rel_q);

  assert_release_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_q) |-> ($past(hold_cnt) == HW'(HOLD_CYCLES - 1)));

endmodule

// File: rtl/clkratio_period_meter.sv
module clkratio_period_meter
  import clkratio_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             core_rst_n,
  input  logic             frame_clk,
  output logic             meas_stb,
  output logic             tmo,
  output logic [LEN_W-1:0] meas_len
);
  localparam int CMAX = (1 << CNT_W) - 1;

  logic             fc_q;
  logic [CNT_W-1:0] per_cnt;
  logic             seen_q;
  logic             rise;

  assign rise     = frame_clk & ~fc_q;
  assign tmo      = ~rise & (per_cnt == CNT_W'(CMAX - 1));
  assign meas_stb = rise & seen_q;
  assign meas_len = LEN_W'(per_cnt) + LEN_W'(1);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      fc_q    <= 1'b1;
      per_cnt <= '0;
      seen_q  <= 1'b0;
    end else begin
      fc_q <= frame_clk;
      if (rise)                           per_cnt <= '0;
      else if (per_cnt != CNT_W'(CMAX))   per_cnt <= per_cnt + CNT_W'(1);
      if (rise)     seen_q <= 1'b1;
      else if (tmo) seen_q <= 1'b0;
    end
  end

  assert_single_timeout_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    tmo |=> !tmo);

endmodule

// File: rtl/clkratio_ratio_tracker.sv
module clkratio_ratio_tracker
  import clkratio_pkg::*;
(
  input  logic             clk,
  input  logic             core_rst_n,
  input  logic             meas_stb,
  input  logic             tmo,
  input  logic [LEN_W-1:0] meas_len,
  output logic             locked,
  output ratio_e           code,
  output logic             bad,
  output logic             lock_evt,
  output logic             drop_evt
);
  logic [LEN_W-1:0] prev_len;
  logic             prev_ok;
  logic             locked_q;
  ratio_e           code_q;
  logic             bad_q;
  class_t           cls;
  logic             same;

  assign cls      = classify(meas_len);
  assign same     = prev_ok && (prev_len == meas_len);
  assign lock_evt = meas_stb && same && cls.ok && (!locked_q || (code_q != cls.code));
  assign drop_evt = tmo || (meas_stb && same && !cls.ok);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      prev_len <= '0;
      prev_ok  <= 1'b0;
      locked_q <= 1'b0;
      code_q   <= RATIO_256;
      bad_q    <= 1'b0;
    end else if (tmo) begin
      locked_q <= 1'b0;
      bad_q    <= 1'b1;
      prev_ok  <= 1'b0;
    end else if (meas_stb) begin
      bad_q    <= ~cls.ok;
      prev_len <= meas_len;
      prev_ok  <= 1'b1;
      if (lock_evt) begin
        locked_q <= 1'b1;
        code_q   <= cls.code;
      end else if (drop_evt) begin
        locked_q <= 1'b0;
      end
    end
  end

  assign locked = locked_q;
  assign code   = code_q;
  assign bad    = bad_q;

  assert_lock_on_valid_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(locked_q) |-> !bad_q);

endmodule

// File: rtl/clkratio_phase_guard.sv
module clkratio_phase_guard
  import clkratio_pkg::*;
#(
  parameter int DIV_BITS       = DIV_W,
  parameter int BITS_PER_FRAME = 64,
  parameter int TOL_BITS       = 6
) (
  input  logic   clk,
  input  logic   core_rst_n,
  input  logic   meas_stb,
  input  logic   locked,
  input  ratio_e code,
  input  logic   lock_evt,
  input  logic   drop_evt,
  output logic   resync,
  output logic   div_tick
);
  logic [DIV_BITS-1:0] div_q;
  logic [DIV_BITS-1:0] div_nxt;
  logic                resync_q;
  logic [LEN_W-1:0]    n_len;
  logic [LEN_W-1:0]    perr;
  logic [LEN_W-1:0]    tol;
  logic                phase_bad;

  assign n_len     = frame_len(code);
  assign tol       = tol_clocks(code, BITS_PER_FRAME, TOL_BITS);
  assign perr      = phase_err(LEN_W'(div_q), n_len);
  assign div_nxt   = (LEN_W'(div_q) == n_len - LEN_W'(1)) ? '0 : div_q + DIV_BITS'(1);
  assign phase_bad = meas_stb && locked && !lock_evt && !drop_evt && (perr > tol);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      div_q    <= '0;
      resync_q <= 1'b0;
    end else if (drop_evt) begin
      div_q    <= '0;
      resync_q <= 1'b0;
    end else if (lock_evt) begin
      div_q    <= DIV_BITS'(1);
      resync_q <= 1'b0;
    end else if (locked) begin
      if (phase_bad) begin
        div_q    <= DIV_BITS'(1);
        resync_q <= 1'b1;
      end else begin
        div_q <= div_nxt;
        if (meas_stb) resync_q <= 1'b0;
      end
    end else begin
      div_q    <= '0;
      resync_q <= 1'b0;
    end
  end

  assign resync   = resync_q;
  assign div_tick = locked && (div_q == '0);

  assert_resync_locked_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    resync_q |-> locked);

  assert_resync_start_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(resync_q) |-> $past(meas_stb));

  assert_resync_end_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    $fell(resync_q) |-> $past(meas_stb || drop_evt));

  assert_div_range_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    LEN_W'(div_q) < n_len);

endmodule

// File: rtl/clkratio_ctrl.sv
module clkratio_ctrl
  import clkratio_pkg::*;
#(
  parameter int CNT_W          = 11,
  parameter int HOLD_CYCLES    = 1024,
  parameter int BITS_PER_FRAME = 64,
  parameter int TOL_BITS       = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_clk,
  output logic       int_rst_n,
  output logic       force_mid,
  output logic       ratio_locked,
  output logic [1:0] ratio_code,
  output logic       period_bad,
  output logic       resync_busy,
  output logic       frame_tick
);
  logic             core_rst_n;
  logic             meas_stb;
  logic             tmo;
  logic [LEN_W-1:0] meas_len;
  logic             locked;
  ratio_e           code;
  logic             bad;
  logic             lock_evt;
  logic             drop_evt;
  logic             resync;
  logic             div_tick;

  clkratio_rst_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_rst_n(core_rst_n)
  );

  clkratio_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk       (clk),
    .core_rst_n(core_rst_n),
    .frame_clk (frame_clk),
    .meas_stb  (meas_stb),
    .tmo       (tmo),
    .meas_len  (meas_len)
  );

  clkratio_ratio_tracker u_track (
    .clk       (clk),
    .core_rst_n(core_rst_n),
    .meas_stb  (meas_stb),
    .tmo       (tmo),
    .meas_len  (meas_len),
    .locked    (locked),
    .code      (code),
    .bad       (bad),
    .lock_evt  (lock_evt),
    .drop_evt  (drop_evt)
  );

  clkratio_phase_guard #(
    .DIV_BITS      (DIV_W),
    .BITS_PER_FRAME(BITS_PER_FRAME),
    .TOL_BITS      (TOL_BITS)
  ) u_phase (
    .clk       (clk),
    .core_rst_n(core_rst_n),
    .meas_stb  (meas_stb),
    .locked    (locked),
    .code      (code),
    .lock_evt  (lock_evt),
    .drop_evt  (drop_evt),
    .resync    (resync),
    .div_tick  (div_tick)
  );

  assign int_rst_n    = core_rst_n;
  assign force_mid    = ~core_rst_n | resync;
  assign ratio_locked = locked;
  assign ratio_code   = code;
  assign period_bad   = bad;
  assign resync_busy  = resync;
  assign frame_tick   = div_tick;

endmodule

// File: tb/clkratio_ctrl_tb_top.sv
module clkratio_ctrl_tb_top;

  localparam int HOLD = 1024;
  localparam int TMAX = 2047;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       frame_clk = 1'b0;
  logic       int_rst_n, force_mid, ratio_locked, period_bad, resync_busy, frame_tick;
  logic [1:0] ratio_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit started = 0;
  bit done    = 0;
  int cyc     = 0;

  always #4 clk = ~clk;

  clkratio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk),
    .int_rst_n(int_rst_n), .force_mid(force_mid), .ratio_locked(ratio_locked),
    .ratio_code(ratio_code), .period_bad(period_bad), .resync_busy(resync_busy),
    .frame_tick(frame_tick)
  );

  // Reference model state (integers, edge-indexed).
  int m_hold = 0, m_rel = 0, edge_i = 0, anchor = 0, align = 0;
  int fc_prev = 1, seen = 0, prev_len = 0, prev_ok = 0;
  int m_locked = 0, m_code = 0, m_bad = 0, m_resync = 0;

  function automatic int len_of(input int c);
    case (c)
      0: return 256;
      1: return 384;
      2: return 512;
      default: return 768;
    endcase
  endfunction

  function automatic int code_of(input int len);
    case (len)
      256: return 0;
      384: return 1;
      512: return 2;
      768: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic model_core_clear();
    fc_prev = 1; seen = 0; prev_ok = 0; prev_len = 0;
    m_locked = 0; m_code = 0; m_bad = 0; m_resync = 0; align = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = 0; m_rel = 0;
      model_core_clear();
    end else begin
      edge_i++;
      if (m_rel == 0) begin
        m_hold++;
        if (m_hold == HOLD) begin
          m_rel = 1; model_core_clear(); anchor = edge_i;
        end
      end else begin
        int r, t, meas, len, c, ok, same, lk, dr, n, ph, perr, tol, old_locked;
        r = (frame_clk && fc_prev == 0) ? 1 : 0;
        fc_prev = frame_clk;
        t = (r == 0 && edge_i - anchor == TMAX) ? 1 : 0;
        meas = (r && seen) ? 1 : 0;
        len = edge_i - anchor;
        if (r) begin anchor = edge_i; seen = 1; end
        if (t) seen = 0;
        c = code_of(len);
        ok = (c >= 0) ? 1 : 0;
        same = (prev_ok && prev_len == len) ? 1 : 0;
        old_locked = m_locked;
        lk = (meas && same && ok && (!old_locked || m_code != c)) ? 1 : 0;
        dr = (t || (meas && same && !ok)) ? 1 : 0;
        n = len_of(m_code);
        ph = (edge_i - align) % n;
        perr = (ph <= n / 2) ? ph : n - ph;
        tol = n * 6 / 64;
        if (t) begin
          m_locked = 0; m_bad = 1; prev_ok = 0;
        end else if (meas) begin
          m_bad = ok ? 0 : 1; prev_len = len; prev_ok = 1;
          if (lk) begin m_locked = 1; m_code = c; end
          else if (dr) m_locked = 0;
        end
        if (dr) m_resync = 0;
        else if (lk) begin m_resync = 0; align = edge_i; end
        else if (old_locked && meas) begin
          if (perr > tol) begin m_resync = 1; align = edge_i; end
          else m_resync = 0;
        end else if (!old_locked) m_resync = 0;
      end
    end
  end

  task automatic check(input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (started && !done) begin
      int exp_tick;
      exp_tick = (m_locked && ((edge_i + 1 - align) % len_of(m_code)) == 0) ? 1 : 0;
      check(int_rst_n, m_rel, "R1 int_rst_n");
      check(force_mid, (!m_rel || m_resync) ? 1 : 0, "R2 force_mid");
      check(ratio_locked, m_locked, "R4 ratio_locked");
      check(ratio_code, m_code, "R4 ratio_code");
      check(period_bad, m_bad, "R6 period_bad");
      check(resync_busy, m_resync, "R8 resync_busy");
      check(frame_tick, exp_tick, "R10 frame_tick");
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic frames(input int len, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      frame_clk = 1'b1;
      repeat (len / 2) tick();
      frame_clk = 1'b0;
      repeat (len - len / 2) tick();
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog (all requirements): got hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    started = 1;
    repeat (3) tick();
    check(int_rst_n, 0, "R1 reset held");
    rst_n = 1'b1;
    repeat (HOLD - 1) tick();
    check(int_rst_n, 0, "R1 still low at 1023");
    check(force_mid, 1, "R2 mute in reset");
    tick();
    check(int_rst_n, 1, "R1 released at 1024");
    check(force_mid, 0, "R2 mute off");

    frames(256, 2);
    check(ratio_locked, 0, "R3 first edge only starts");
    frames(256, 2);
    check(ratio_locked, 1, "R4 lock 256");
    check(ratio_code, 0, "R4 code 256");

    frames(280, 1); frames(256, 1);
    check(period_bad, 1, "R6 odd period flagged");
    check(ratio_locked, 1, "R5 odd period keeps lock");
    check(resync_busy, 0, "R8 error at limit ignored");
    frames(257, 1); frames(256, 1);
    check(resync_busy, 1, "R8 error over limit");
    check(force_mid, 1, "R2 mute in resync");
    frames(256, 1);
    check(resync_busy, 0, "R9 resync ends on frame");

    frames(226, 1); frames(256, 1);
    check(resync_busy, 1, "R8 early edge");
    frames(256, 1);
    check(resync_busy, 0, "R9 early edge recovered");

    frames(384, 4);
    check(ratio_locked, 1, "R5 relock keeps lock");
    check(ratio_code, 1, "R5 code 384");
    check(resync_busy, 0, "R9 cleared by lock change");
    frames(420, 1); frames(384, 1);
    check(resync_busy, 0, "R8 384 at limit");
    frames(385, 1); frames(384, 1);
    check(resync_busy, 1, "R8 384 over limit");
    frames(384, 1);
    check(resync_busy, 0, "R9 384 recovered");

    frames(512, 4);
    check(ratio_code, 2, "R4 code 512");
    frames(768, 4);
    check(ratio_code, 3, "R4 code 768");

    frames(300, 4);
    check(ratio_locked, 0, "R6 invalid drops lock");
    check(period_bad, 1, "R6 invalid flagged");
    check(resync_busy, 0, "R9 cleared on drop");

    frames(512, 4);
    check(ratio_locked, 1, "R4 relock 512");
    repeat (2100) tick();
    check(ratio_locked, 0, "R7 timeout drops lock");
    check(period_bad, 1, "R7 timeout flagged");
    frames(512, 2);
    check(ratio_locked, 0, "R7 restart after timeout");
    frames(512, 1);
    check(ratio_locked, 1, "R7 relock after timeout");

    rst_n = 1'b0;
    tick();
    check(int_rst_n, 0, "R1 async reset");
    check(ratio_locked, 0, "R1 lock cleared");
    check(force_mid, 1, "R2 mute on reset");
    rst_n = 1'b1;
    repeat (4) tick();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule